// File: doc/BRIEF.md
# Table-Based YCbCr to RGB565 Pixel Converter

This block turns a stream of 8-bit luma/chroma triples (Y, Cb, Cr) into 16-bit RGB565 words that can be written directly to a 16-bit-wide frame memory. It uses no multipliers. Five constant tables, each indexed by one 8-bit component, hold the coefficient products at double scale, rounded to the nearest integer. A second stage adds the table outputs and a fixed integer offset for each colour channel. It then clamps each sum at zero, halves it, saturates it at 255 and packs the top bits of the three channels into one word.

The input and output are valid/ready streams. The block accepts one triple per clock whenever `i_ready` is high. `i_ready` equals `!o_valid || o_ready`, so the two pipeline stages advance together and stall together. While `o_valid` is high and `o_ready` is low, the output word and `o_wr` are held and nothing new is accepted. A producer that sees `i_ready` low keeps offering the same triple. Words leave in the order their triples arrived, and none is dropped or duplicated. With `o_ready` held high, a word appears two clocks after its triple is accepted.

`o_wr` qualifies the output as a memory write. It is high only for a valid word that is not all zero, so pure black pixels produce no write.

Top module: `ycc2rgb565`

## Requirements
- R1: After synchronous reset (`rst` high), `o_valid` and `o_wr` are 0. Once `rst` is low with nothing in flight, `i_ready` is 1.
- R2: Doubled red is Ty + Trv − 446, where Ty = round(2·1.164·Y) and Trv = round(2·1.596·Cr), each rounded to the nearest integer.
- R3: Doubled green is Ty − Tgv − Tgu + 271, where Tgv = round(2·0.813·Cr) and Tgu = round(2·0.392·Cb).
- R4: Doubled blue is Ty + Tbu − 554, where Tbu = round(2·2.017·Cb).
- R5: Each doubled value v maps to a channel value of 0 when v ≤ 0, of 255 when v/2 exceeds 255, and of floor(v/2) otherwise. Black (16,128,128) gives R=G=B=0. White (235,128,128) gives R=255, G=255, B=254.
- R6: The output word is `o_pix[15:11]` = R[7:3], `o_pix[10:5]` = G[7:2] and `o_pix[4:0]` = B[7:3].
- R7: `o_wr` is high exactly when `o_valid` is high and `o_pix` is not zero.
- R8: With `o_ready` held high, a triple accepted at a clock edge produces `o_valid` on the word at the second following edge, and one triple can be accepted every clock.
- R9: While `o_valid` is high and `o_ready` is low, `i_ready` is low and `o_valid`, `o_pix` and `o_wr` stay unchanged. Words come out in input order with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input triple offered |
| i_ready | output | 1 | Block can accept a triple this cycle |
| i_y | input | 8 | Luma sample |
| i_cb | input | 8 | Blue-difference chroma sample |
| i_cr | input | 8 | Red-difference chroma sample |
| o_valid | output | 1 | Output word present |
| o_ready | input | 1 | Consumer takes the output word this cycle |
| o_pix | output | 16 | Packed RGB565 word |
| o_wr | output | 1 | Write qualifier: valid and non-zero word |

## Verification
The assertions assume that `i_valid` is low while `rst` is high. They also assume that `o_ready` is a plain level settled before each edge, and that a producer facing a low `i_ready` keeps its triple until it is taken. The bench drives every input at the falling edge and raises `i_valid` only after reset is released. In the random phases, it re-offers the same triple on each cycle until a handshake happens. It first runs with `o_ready` tied high, so that the two-cycle latency is exercised cleanly. It then toggles `o_ready` at random, so that held words and stalled input are exercised together.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int CW   = 8;          // component width
  localparam int TW   = CW + 3;     // table entry width (max 1029)
  localparam int SW   = TW + 3;     // signed sum width
  localparam int PW   = 16;         // packed word width
  localparam int RB   = 5;
  localparam int GB   = 6;
  localparam int BB   = 5;
  localparam int SCALE = 1000;

  // doubled coefficients, in thousandths
  localparam int K_Y  = 2328;
  localparam int K_RV = 3192;
  localparam int K_GV = 1626;
  localparam int K_GU = 784;
  localparam int K_BU = 4034;

  // doubled-scale offsets
  localparam int OFS_R = 446;
  localparam int OFS_G = 271;
  localparam int OFS_B = 554;

  typedef struct packed {
    logic [TW-1:0] ty;
    logic [TW-1:0] trv;
    logic [TW-1:0] tgv;
    logic [TW-1:0] tgu;
    logic [TW-1:0] tbu;
  } terms_t;

  function automatic int dbl_term(input int k, input int x);
    return (k * x + SCALE / 2) / SCALE;
  endfunction
endpackage

// File: rtl/coef_rom.sv
module coef_rom
  import ycc_pkg::*;
#(
  parameter int K = 1000
) (
  input  logic [CW-1:0] idx,
  output logic [TW-1:0] val
);
  localparam int NENT = 1 << CW;

  logic [TW-1:0] tbl [NENT];

  for (genvar gi = 0; gi < NENT; gi++) begin : g_ent
    assign tbl[gi] = TW'(dbl_term(K, gi));
  end

  assign val = tbl[idx];
endmodule

// File: rtl/ycc_lookup_stage.sv
module ycc_lookup_stage
  import ycc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          in_valid,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] cb,
  input  logic [CW-1:0] cr,
  output logic          s1_valid,
  output terms_t        s1_terms
);
  terms_t look;

  coef_rom #(.K(K_Y))  u_ty  (.idx(y),  .val(look.ty));
  coef_rom #(.K(K_RV)) u_trv (.idx(cr), .val(look.trv));
  coef_rom #(.K(K_GV)) u_tgv (.idx(cr), .val(look.tgv));
  coef_rom #(.K(K_GU)) u_tgu (.idx(cb), .val(look.tgu));
  coef_rom #(.K(K_BU)) u_tbu (.idx(cb), .val(look.tbu));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_terms <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) s1_terms <= look;
    end
  end

  // R9
  s1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !adv) |=> s1_valid);
endmodule

// File: rtl/ycc_combine_stage.sv
module ycc_combine_stage
  import ycc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          s1_valid,
  input  terms_t        s1_terms,
  output logic          o_valid,
  output logic [PW-1:0] o_pix,
  output logic          o_wr
);
  localparam logic signed [SW-1:0] KR   = SW'(OFS_R);
  localparam logic signed [SW-1:0] KG   = SW'(OFS_G);
  localparam logic signed [SW-1:0] KB   = SW'(OFS_B);
  localparam logic signed [SW-1:0] ZERO = '0;
  localparam logic signed [SW-1:0] SLIM = SW'((1 << (CW + 1)) - 1);

  function automatic logic signed [SW-1:0] ext(input logic [TW-1:0] t);
    return $signed({{(SW-TW){1'b0}}, t});
  endfunction

  function automatic logic [CW-1:0] clamp_half(input logic signed [SW-1:0] v);
    if (v <= ZERO)      return '0;
    else if (v > SLIM)  return '1;
    else                return v[CW:1];
  endfunction

  logic signed [SW-1:0] r2, g2, b2;
  logic [CW-1:0]        rc, gc, bc;
  logic [PW-1:0]        packed_w;

  always_comb begin
    r2 = ext(s1_terms.ty) + ext(s1_terms.trv) - KR;
    g2 = ext(s1_terms.ty) - ext(s1_terms.tgv) - ext(s1_terms.tgu) + KG;
    b2 = ext(s1_terms.ty) + ext(s1_terms.tbu) - KB;
    rc = clamp_half(r2);
    gc = clamp_half(g2);
    bc = clamp_half(b2);
    packed_w = {rc[CW-1 -: RB], gc[CW-1 -: GB], bc[CW-1 -: BB]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_pix   <= '0;
      o_wr    <= 1'b0;
    end else if (adv) begin
      o_valid <= s1_valid;
      o_pix   <= packed_w;
      o_wr    <= s1_valid && (packed_w != '0);
    end
  end

  // R7
  wr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    o_wr |-> (o_valid && (o_pix != '0)));
  // R7
  wr_present_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && (o_pix != '0)) |-> o_wr);
endmodule

// File: rtl/ycc2rgb565.sv
module ycc2rgb565
  import ycc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic [CW-1:0] i_y,
  input  logic [CW-1:0] i_cb,
  input  logic [CW-1:0] i_cr,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [PW-1:0] o_pix,
  output logic          o_wr
);
  logic   adv;
  logic   s1_valid;
  terms_t s1_terms;

  assign adv     = !o_valid || o_ready;
  assign i_ready = adv;

  ycc_lookup_stage u_look (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (i_valid),
    .y        (i_y),
    .cb       (i_cb),
    .cr       (i_cr),
    .s1_valid (s1_valid),
    .s1_terms (s1_terms)
  );

  ycc_combine_stage u_comb (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .s1_valid (s1_valid),
    .s1_terms (s1_terms),
    .o_valid  (o_valid),
    .o_pix    (o_pix),
    .o_wr     (o_wr)
  );

  // R8
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(!rst) && $past(i_valid && i_ready, 2) && $past(o_ready))
      |-> o_valid);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_pix) && $stable(o_wr)));
  // R9
  backpress_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |-> !i_ready);
endmodule

// File: tb/sim_ycc2rgb565.sv
`timescale 1ns/1ps
module sim_ycc2rgb565;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_valid = 1'b0, o_ready = 1'b1;
  logic [7:0] i_y = '0, i_cb = '0, i_cr = '0;
  logic i_ready, o_valid, o_wr;
  logic [15:0] o_pix;

  always #2 clk = ~clk;

  ycc2rgb565 u0 (.clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready),
    .i_y(i_y), .i_cb(i_cb), .i_cr(i_cr), .o_valid(o_valid), .o_ready(o_ready),
    .o_pix(o_pix), .o_wr(o_wr));

  int checks = 0, fails = 0, cyc = 0;
  int exp_pix[$];
  int exp_cyc[$];
  int exp_strict[$];
  string exp_tag[$];
  bit strict = 1'b1;
  bit hold_pend = 1'b0;
  logic [15:0] hold_pix;
  bit done = 1'b0;

  // nearest-integer product at double scale, k in thousandths
  function automatic int tv(int k, int x);
    return (4 * k * x + 1000) / 2000;
  endfunction
  function automatic int chan(int v);
    if (v <= 0) return 0;
    if (v / 2 > 255) return 255;
    return v / 2;
  endfunction
  function automatic int model(int y, int cb, int cr);
    int r, g, b;
    r = chan(tv(1164, y) + tv(1596, cr) - 446);
    g = chan(tv(1164, y) - tv(813, cr) - tv(392, cb) + 271);
    b = chan(tv(1164, y) + tv(2017, cb) - 554);
    return ((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // drive one cycle; fired reports input handshake
  task automatic step(bit v, int y, int cb, int cr, bit rdy, string tag, output bit fired);
    @(negedge clk);
    cyc++;
    if (hold_pend) begin
      chk(o_valid && o_pix == hold_pix, "R9 hold", o_pix, hold_pix);
      chk(!i_ready, "R9 i_ready low", i_ready, 0);
      hold_pend = 1'b0;
    end
    i_valid = v; i_y = y[7:0]; i_cb = cb[7:0]; i_cr = cr[7:0]; o_ready = rdy;
    if (!rdy) strict = 1'b0;
    #1;
    chk(i_ready == (!o_valid || o_ready), "R9 ready rule", i_ready, !o_valid || o_ready);
    if (o_valid && o_ready) begin
      if (exp_pix.size() == 0) chk(0, "R9 unexpected word", o_pix, 0);
      else begin
        int e = exp_pix.pop_front();
        int c = exp_cyc.pop_front();
        int s = exp_strict.pop_front();
        string t = exp_tag.pop_front();
        chk(o_pix[15:11] == e[15:11], {t, " R2 red"}, o_pix, e);
        chk(o_pix[10:5] == e[10:5], {t, " R3 green"}, o_pix, e);
        chk(o_pix[4:0] == e[4:0], {t, " R4 blue"}, o_pix, e);
        chk(o_wr == (e != 0), "R7 write gate", o_wr, e != 0);
        if (s != 0 && strict) chk(cyc - c == 2, "R8 latency", cyc - c, 2);
      end
    end
    if (o_valid && !o_ready) begin
      hold_pend = 1'b1;
      hold_pix = o_pix;
    end
    fired = v && i_ready;
    if (fired) begin
      exp_pix.push_back(model(y, cb, cr));
      exp_cyc.push_back(cyc);
      exp_strict.push_back(int'(strict));
      exp_tag.push_back(tag);
    end
  endtask

  task automatic send(int y, int cb, int cr, bit rdy_rand, string tag);
    bit f = 1'b0;
    while (!f) step(1'b1, y, cb, cr, rdy_rand ? bit'($urandom_range(0, 2) != 0) : 1'b1, tag, f);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit f;
    repeat (3) @(negedge clk);
    chk(!o_valid && !o_wr, "R1 reset outputs", {o_valid, o_wr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(i_ready, "R1 ready after reset", i_ready, 1);
    // directed corners
    send(16, 128, 128, 0, "R5 R7 black");
    send(235, 128, 128, 0, "R5 R6 white");
    send(255, 255, 255, 0, "R5 high sat");
    send(0, 0, 0, 0, "R5 low clamp");
    send(255, 0, 0, 0, "R5 mixed");
    send(0, 255, 255, 0, "R5 chroma max");
    send(128, 128, 128, 0, "R6 mid");
    step(1'b0, 0, 0, 0, 1'b1, "", f);
    step(1'b0, 0, 0, 0, 1'b1, "", f);
    step(1'b0, 0, 0, 0, 1'b1, "", f);
    // back-to-back, ready held high
    for (int i = 0; i < 300; i++)
      send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), 0, "R8 stream");
    // random valid and back-pressure
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 3) == 0) step(1'b0, 0, 0, 0, bit'($urandom_range(0, 1)), "", f);
      else send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), 1, "R9 stall");
    end
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 0, 1'b1, "", f);
    chk(exp_pix.size() == 0, "R9 none lost", exp_pix.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule